// File: doc/BRIEF.md
# Loadable BCD Decade Counter Digit

This block is one decimal digit of a synchronous counter. It steps through 0 to 9 on rising clock edges and wraps back to 0. A parallel value can be loaded at any edge, and a master reset clears it at once, without waiting for the clock. Counting needs two enables. A local enable lets software or control logic pause the digit. A chain enable comes from the previous digit.

The carry output flags the last code of the digit and is qualified by the chain enable only. Wiring each digit's carry into the chain enable of the next digit gives a multi-digit counter in which every digit updates on the same clock edge. The carry look-ahead needs no gates outside the digits.

The modulus is a parameter (`RADIX`, default 10), and the data width is derived from it. Any code at or above `RADIX - 1` steps to 0. A value loaded outside the valid range therefore returns to the range on the next enabled edge.

Top module: `bcd_digit_counter`

## Requirements
- R1: While `rst_n_i` is high, `count_o` changes only at a rising edge of `clk_i`. A low on `rst_n_i` drives `count_o` to 0 and `carry_o` to 0 immediately, without a clock edge.
- R2: When `load_n_i` is low at a rising edge, `count_o` takes the value of `data_i` on that edge, whatever the levels of `cnt_en_i` and `chain_en_i`.
- R3: When `load_n_i` is high and both `cnt_en_i` and `chain_en_i` are high at a rising edge, a count of 0 to 8 increases by one, and a count of 9 becomes 0.
- R4: When `load_n_i` is high and either enable is low at a rising edge, `count_o` keeps its value, and `data_i` has no effect.
- R5: `carry_o` is high exactly when `count_o` equals 9 and `chain_en_i` is high. It follows `chain_en_i` combinationally, between clock edges.
- R6: A loaded code from 10 to 15 is held while counting is disabled, and the next enabled count edge turns it into 0.
- R7: Reset has priority over load: while `rst_n_i` is low, a low `load_n_i` has no effect at a clock edge. The first rising edge after `rst_n_i` goes high acts normally.
- R8: Two digits form a two-digit decimal counter when the carry of the low digit drives the chain enable of the high digit. This counter steps synchronously from 00 to 99 and then wraps to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_n_i | input | 1 | Asynchronous master reset, active low |
| load_n_i | input | 1 | Synchronous parallel load, active low |
| cnt_en_i | input | 1 | Local count enable, active high |
| chain_en_i | input | 1 | Chain count enable, active high, also gates `carry_o` |
| data_i | input | W (4) | Parallel load value |
| count_o | output | W (4) | Current count |
| carry_o | output | 1 | Terminal-count flag for cascading |

## Verification
The bench builds the counter and both digits of the cascade with the default `RADIX` of 10. At that setting the 4-bit state can hold the six codes from 10 to 15, so the out-of-range loads and their recovery to 0 can be reached. The compare-based wrap branch is also the one in use. The two-digit cascade runs through all 100 combined states, including the edge where both carries are high together and the pair rolls from 99 to 00.

// File: rtl/bcd_ctr_pkg.sv
`timescale 1ns/1ps
package bcd_ctr_pkg;
  // Action taken by the digit at the next rising edge
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_STEP = 2'd2
  } ctr_op_e;
endpackage

// File: rtl/bcd_ctr_ctl.sv
`timescale 1ns/1ps
module bcd_ctr_ctl
  import bcd_ctr_pkg::*;
(
  input  logic    load_n,
  input  logic    cnt_en,
  input  logic    chain_en,
  output ctr_op_e op
);
  // Load wins over both enables; stepping needs both enables
  always_comb begin
    if (!load_n)                op = OP_LOAD;
    else if (cnt_en && chain_en) op = OP_STEP;
    else                        op = OP_HOLD;
  end
endmodule

// File: rtl/bcd_ctr_next.sv
`timescale 1ns/1ps
module bcd_ctr_next
  import bcd_ctr_pkg::*;
#(
  parameter int RADIX = 10,
  parameter int W     = 4
) (
  input  ctr_op_e        op,
  input  logic [W-1:0]   cur,
  input  logic [W-1:0]   load_val,
  output logic [W-1:0]   nxt
);
  localparam logic [W-1:0] LAST     = W'(RADIX - 1);
  localparam bit           FULL_BIN = (RADIX == (1 << W));

  logic [W-1:0] stepped;

  generate
    if (FULL_BIN) begin : g_natural_wrap
      // Modulus fills the register: the adder wraps on its own
      assign stepped = cur + W'(1);
    end else begin : g_compare_wrap
      // Last code and every unused code above it go to zero
      assign stepped = (cur >= LAST) ? '0 : cur + W'(1);
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_LOAD: nxt = load_val;
      OP_STEP: nxt = stepped;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/bcd_ctr_reg.sv
`timescale 1ns/1ps
module bcd_ctr_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/bcd_ctr_tc.sv
`timescale 1ns/1ps
module bcd_ctr_tc #(
  parameter int RADIX = 10,
  parameter int W     = 4
) (
  input  logic [W-1:0] cur,
  input  logic         chain_en,
  output logic         carry
);
  localparam logic [W-1:0] LAST = W'(RADIX - 1);
  // Only the chain enable qualifies the flag, so it ripples ahead of the clock
  assign carry = chain_en && (cur == LAST);
endmodule

// File: rtl/bcd_digit_counter.sv
`timescale 1ns/1ps
module bcd_digit_counter
  import bcd_ctr_pkg::*;
#(
  parameter int  RADIX = 10,
  localparam int W     = (RADIX < 2) ? 1 : $clog2(RADIX)
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic         load_n_i,
  input  logic         cnt_en_i,
  input  logic         chain_en_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] count_o,
  output logic         carry_o
);
  ctr_op_e      op;
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  bcd_ctr_ctl u_ctl (
    .load_n   (load_n_i),
    .cnt_en   (cnt_en_i),
    .chain_en (chain_en_i),
    .op       (op)
  );

  bcd_ctr_next #(.RADIX(RADIX), .W(W)) u_next (
    .op       (op),
    .cur      (state_q),
    .load_val (data_i),
    .nxt      (state_d)
  );

  bcd_ctr_reg #(.W(W)) u_reg (
    .clk   (clk_i),
    .rst_n (rst_n_i),
    .d     (state_d),
    .q     (state_q)
  );

  bcd_ctr_tc #(.RADIX(RADIX), .W(W)) u_tc (
    .cur      (state_q),
    .chain_en (chain_en_i),
    .carry    (carry_o)
  );

  assign count_o = state_q;
endmodule

// File: rtl/bcd_digit_counter_chk.sv
`timescale 1ns/1ps
module bcd_digit_counter_chk #(
  parameter int  RADIX = 10,
  localparam int W     = (RADIX < 2) ? 1 : $clog2(RADIX)
) (
  input logic         clk_i,
  input logic         rst_n_i,
  input logic         load_n_i,
  input logic         cnt_en_i,
  input logic         chain_en_i,
  input logic [W-1:0] data_i,
  input logic [W-1:0] count_o,
  input logic         carry_o
);
  localparam logic [W-1:0] LAST = W'(RADIX - 1);

  // R1
  reset_clears_chk: assert property (@(posedge clk_i)
    !rst_n_i |-> (count_o == '0) && !carry_o);

  // R2
  load_takes_data_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !load_n_i |=> count_o == $past(data_i));

  // R3
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (load_n_i && cnt_en_i && chain_en_i && count_o < LAST)
      |=> count_o == $past(count_o) + W'(1));

  // R3 R6
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (load_n_i && cnt_en_i && chain_en_i && count_o >= LAST) |=> count_o == '0);

  // R4
  hold_value_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (load_n_i && !(cnt_en_i && chain_en_i)) |=> $stable(count_o));

  // R5
  carry_needs_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    carry_o |-> chain_en_i && (count_o == LAST));
endmodule

bind bcd_digit_counter bcd_digit_counter_chk #(.RADIX(RADIX)) u_chk (
  .clk_i      (clk_i),
  .rst_n_i    (rst_n_i),
  .load_n_i   (load_n_i),
  .cnt_en_i   (cnt_en_i),
  .chain_en_i (chain_en_i),
  .data_i     (data_i),
  .count_o    (count_o),
  .carry_o    (carry_o)
);

// File: tb/tb_bcd_digit_counter.sv
`timescale 1ns/1ps
module tb_bcd_digit_counter;
  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic       rst_n = 1'b0;
  logic       load_n = 1'b1;
  logic       en = 1'b0;
  logic       ch = 1'b0;
  logic [3:0] data = 4'd0;
  logic [3:0] count;
  logic       carry;

  bcd_digit_counter dut (
    .clk_i(clk), .rst_n_i(rst_n), .load_n_i(load_n), .cnt_en_i(en),
    .chain_en_i(ch), .data_i(data), .count_o(count), .carry_o(carry)
  );

  // Two-digit cascade for R8
  logic       rst_c_n = 1'b0;
  logic [3:0] lo_q, hi_q;
  logic       lo_c, hi_c;

  bcd_digit_counter u_lo (
    .clk_i(clk), .rst_n_i(rst_c_n), .load_n_i(1'b1), .cnt_en_i(1'b1),
    .chain_en_i(1'b1), .data_i(4'd0), .count_o(lo_q), .carry_o(lo_c)
  );
  bcd_digit_counter u_hi (
    .clk_i(clk), .rst_n_i(rst_c_n), .load_n_i(1'b1), .cnt_en_i(1'b1),
    .chain_en_i(lo_c), .data_i(4'd0), .count_o(hi_q), .carry_o(hi_c)
  );

  // Row: {load_n, en, chain, data[3:0], expected count[3:0], expected carry}
  localparam int NV = 18;
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd1,  1'b0},  // step
    {1'b1, 1'b1, 1'b1, 4'd5,  4'd2,  1'b0},  // step, data ignored
    {1'b1, 1'b0, 1'b1, 4'd5,  4'd2,  1'b0},  // hold, local enable low
    {1'b1, 1'b1, 1'b0, 4'd6,  4'd2,  1'b0},  // hold, chain enable low
    {1'b0, 1'b0, 1'b0, 4'd7,  4'd7,  1'b0},  // load, enables low
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd8,  1'b0},
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd9,  1'b1},  // terminal code with chain high
    {1'b1, 1'b1, 1'b0, 4'd3,  4'd9,  1'b0},  // hold, carry gated off
    {1'b1, 1'b0, 1'b1, 4'd3,  4'd9,  1'b1},  // hold, carry needs chain only
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0},  // wrap 9 -> 0
    {1'b0, 1'b1, 1'b1, 4'd12, 4'd12, 1'b0},  // out-of-range load
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0},  // recovers to 0
    {1'b0, 1'b1, 1'b1, 4'd15, 4'd15, 1'b0},
    {1'b1, 1'b0, 1'b0, 4'd1,  4'd15, 1'b0},  // held while disabled
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0},
    {1'b0, 1'b1, 1'b1, 4'd9,  4'd9,  1'b1},  // load with enables high
    {1'b0, 1'b1, 1'b1, 4'd3,  4'd3,  1'b0},
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd4,  1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic l, input logic e, input logic c, input logic [3:0] d);
    @(negedge clk);
    load_n = l; en = e; ch = c; data = d;
    @(posedge clk);
    #5;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R1 reset count", count, 0);
    check("R1 reset carry", carry, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Vector table covering R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:5]);
      check($sformatf("R2 R3 R4 R5 R6 row %0d count", i), count, VEC[i][4:1]);
      check($sformatf("R2 R3 R4 R5 R6 row %0d carry", i), carry, VEC[i][0]);
    end

    // R1: inputs changing between edges do not move the count
    @(negedge clk);
    load_n = 1'b0; en = 1'b1; ch = 1'b1; data = 4'd2;
    #3;
    check("R1 no change between edges", count, 4);

    // R5: carry follows the chain enable without a clock
    drive(1'b0, 1'b0, 1'b0, 4'd9);
    check("R5 carry low with chain low", carry, 0);
    #2 ch = 1'b1;
    #1 check("R5 carry rises with chain", carry, 1);
    #2 ch = 1'b0;
    #1 check("R5 carry falls with chain", carry, 0);
    #2 ch = 1'b1;
    #1;

    // R1: asynchronous reset clears count and carry at once
    rst_n = 1'b0;
    #1;
    check("R1 async reset count", count, 0);
    check("R1 async reset carry", carry, 0);

    // R7: reset overrides a pending load
    drive(1'b0, 1'b1, 1'b1, 4'd6);
    check("R7 load blocked by reset", count, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #5;
    check("R7 first edge after release loads", count, 6);
    drive(1'b1, 1'b1, 1'b1, 4'd0);
    check("R7 counting resumes", count, 7);

    // R8: two-digit cascade 00..99 and wrap
    @(negedge clk);
    rst_c_n = 1'b1;
    for (int k = 1; k <= 100; k++) begin
      @(posedge clk);
      #5;
      check($sformatf("R8 cascade step %0d", k), int'(hi_q) * 10 + int'(lo_q), k % 100);
      if (k == 99) check("R8 upper carry at 99", hi_c, 1);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule